// File: doc/BRIEF.md
# H-Bridge Capable Six-Channel PWM Controller

The block drives six pulse-width-modulated outputs from one shared up-counter. The counter runs from 0 up to a programmable period value and then wraps. A 3-bit code selects how finely the system clock is divided before it advances the counter. Each channel holds an internal compare value. Its output is high while the counter is below that value. New compare values from the user ports move into the internal registers only at the counter step from 0 to 1, so a period never runs with a half-updated set of duty cycles.

The control word comes in on plain input ports. In standard mode the six channels run independently. Setting H-bridge mode applies further controls to outputs 0 to 3:
- a direction select that silences one output pair;
- a high-side-off override;
- a global output inversion;
- a gate on compare reloading.

Outputs 1, 3 and 5 can each be inverted on their own in either mode. There are two active-low external inputs, each passing through a two-flop synchronizer. A falling edge on the sync input restarts the time base. A low level on the trip input shuts the outputs down and raises a sticky interrupt.

Top module: `hbridge_pwm`

## Requirements
- R1: During and after a synchronous reset, `pwm_out` is 0, `trip_irq` is 0 and `tripped` is 0. The counter and every internal compare value are 0.
- R2: The counter advances once every 2^(n+1) clocks, where n is `cfg_prescale`. Code 0 gives one step per 2 clocks and code 7 gives one step per 256 clocks.
- R3: The counter counts 0, 1, …, `period`, 0, … Before gating and inversion, output i is high while the counter is below the internal compare value of channel i. That value is bits [8i+7:8i] of `cmp_values` at the default width.
- R4: At a counter step from 0 to 1 (with `period` not 0), the internal compare values load from `cmp_values`. This happens on every such step in standard mode. In H-bridge mode it happens only when `cfg_reload` is 1; otherwise the old values stay in use.
- R5: When `cfg_sync_en` is 1, a high-to-low transition of `sync_n` clears both the counter and the prescaler. This takes effect on the clock edge after the transition has passed a two-flop synchronizer and been detected. When `cfg_sync_en` is 0, `sync_n` has no effect.
- R6: When `cfg_trip_en` is 1 and the synchronized `trip_n` is low, `tripped` and `trip_irq` are set. `tripped` gates the outputs off until `cfg_enable` is taken low. `trip_irq` stays set until an `irq_clr` pulse arrives, and a new trip condition wins over the clear.
- R7: When `cfg_enable` is 0 or `tripped` is 1, every output is forced low before any inversion is applied.
- R8: In H-bridge mode with outputs enabled and `cfg_hs_off` set, outputs 0 and 2 are forced high and outputs 1 and 3 are forced low, before inversion.
- R9: In H-bridge mode with outputs enabled and `cfg_hs_off` clear, `cfg_dir` = 1 holds outputs 2 and 3 low and `cfg_dir` = 0 holds outputs 0 and 1 low.
- R10: `cfg_inv_odd` bits 0, 1 and 2 invert outputs 1, 3 and 5 in both modes. In H-bridge mode `cfg_inv_all` then inverts all six outputs.
- R11: In standard mode (`cfg_hbridge` = 0), `cfg_dir`, `cfg_hs_off`, `cfg_inv_all` and `cfg_reload` have no effect on any output.
- R12: `pwm_out` is a register. It shows the counter, the compare values and the control inputs as they were at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Master output enable |
| cfg_hbridge | input | 1 | Selects H-bridge mode |
| cfg_dir | input | 1 | H-bridge direction: 1 drives outputs 0/1, 0 drives outputs 2/3 |
| cfg_hs_off | input | 1 | H-bridge high-side-off override |
| cfg_reload | input | 1 | H-bridge gate on compare reloading |
| cfg_inv_all | input | 1 | H-bridge global inversion |
| cfg_inv_odd | input | 3 | Inverts outputs 1, 3, 5 (bits 0, 1, 2) |
| cfg_sync_en | input | 1 | Enables the sync restart |
| cfg_trip_en | input | 1 | Enables the trip shutdown |
| cfg_prescale | input | PS_W | Clock division code, divide by 2^(n+1) |
| period | input | CNT_W | Last counter value before wrap |
| cmp_values | input | 6*CNT_W | User compare values, channel i at [CNT_W*i +: CNT_W] |
| sync_n | input | 1 | Asynchronous sync input, falling edge acts |
| trip_n | input | 1 | Asynchronous trip input, low level acts |
| irq_clr | input | 1 | Write-one-to-clear pulse for the trip interrupt |
| pwm_out | output | 6 | Registered PWM outputs |
| trip_irq | output | 1 | Sticky trip interrupt |
| tripped | output | 1 | Outputs are held off by a trip |

## Verification
Directed duty-cycle windows at prescale codes 0 and 7 check the two ends of the divider. Both are set up to give the same high-time count, so a wrong shift amount shows as a different count. Directed phases follow:
- compare writes in H-bridge mode with reload off and then on, which separates a held compare value from a reloaded one;
- sync edges with the restart disabled and then enabled;
- a trip pulse, then enable toggling, then an interrupt clear, which separates the `tripped` state from the sticky interrupt.

Random segments then mix every control bit, random periods and compares, and sparse sync and trip activity. Each cycle is compared against an independently written cycle model.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int NUM_OUT = 6;

  typedef struct packed {
    logic hbridge;
    logic dir;
    logic hs_off;
    logic inv_all;
  } hb_ctrl_t;
endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbp_prescale.sv
module hbp_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] code,
  input  logic            clear,
  output logic            tick
);
  localparam int DIV_W = 1 << PS_W;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] limit;

  // limit = 2^(code+1) - 1: bits 0..code set
  always_comb begin
    limit = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i <= int'(code)) limit[i] = 1'b1;
    end
  end

  assign tick = (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || clear) pre_q <= '0;
    else if (tick)    pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/hbp_timebase.sv
module hbp_timebase #(
  parameter int CNT_W = 8,
  parameter int NCH   = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 clear,
  input  logic                 load_ok,
  input  logic [CNT_W-1:0]     period,
  input  logic [NCH*CNT_W-1:0] cmp_flat,
  output logic [CNT_W-1:0]     cnt,
  output logic [NCH-1:0]       raw
);
  logic [CNT_W-1:0] cnt_q;
  logic             step01;

  assign step01 = tick && !clear && (cnt_q == '0) && (period != '0);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (tick)    cnt_q <= (cnt_q >= period) ? '0 : cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [CNT_W-1:0] shadow_q;

    always_ff @(posedge clk) begin
      if (rst)                     shadow_q <= '0;
      else if (step01 && load_ok)  shadow_q <= cmp_flat[ch*CNT_W +: CNT_W];
    end

    assign raw[ch] = (cnt_q < shadow_q);
  end
endmodule

// File: rtl/hbp_outstage.sv
module hbp_outstage
  import hbp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OUT-1:0] raw,
  input  logic               en,
  input  hb_ctrl_t           ctrl,
  input  logic [2:0]         inv_odd,
  output logic [NUM_OUT-1:0] pwm_q
);
  logic [NUM_OUT-1:0] gated;
  logic [NUM_OUT-1:0] steered;
  logic [NUM_OUT-1:0] shaped;

  always_comb begin
    gated = en ? raw : '0;

    steered = gated;
    if (ctrl.hbridge && en) begin
      if (ctrl.hs_off) begin
        steered[0] = 1'b1;
        steered[2] = 1'b1;
        steered[1] = 1'b0;
        steered[3] = 1'b0;
      end else if (ctrl.dir) begin
        steered[3:2] = 2'b00;
      end else begin
        steered[1:0] = 2'b00;
      end
    end

    shaped    = steered;
    shaped[1] = steered[1] ^ inv_odd[0];
    shaped[3] = steered[3] ^ inv_odd[1];
    shaped[5] = steered[5] ^ inv_odd[2];
    if (ctrl.hbridge && ctrl.inv_all) shaped = ~shaped;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= '0;
    else     pwm_q <= shaped;
  end
endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm
  import hbp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_enable,
  input  logic                     cfg_hbridge,
  input  logic                     cfg_dir,
  input  logic                     cfg_hs_off,
  input  logic                     cfg_reload,
  input  logic                     cfg_inv_all,
  input  logic [2:0]               cfg_inv_odd,
  input  logic                     cfg_sync_en,
  input  logic                     cfg_trip_en,
  input  logic [PS_W-1:0]          cfg_prescale,
  input  logic [CNT_W-1:0]         period,
  input  logic [NUM_OUT*CNT_W-1:0] cmp_values,
  input  logic                     sync_n,
  input  logic                     trip_n,
  input  logic                     irq_clr,
  output logic [NUM_OUT-1:0]       pwm_out,
  output logic                     trip_irq,
  output logic                     tripped
);
  logic sync_q, sync_prev, sync_fall, sync_clear;
  logic trip_q, trip_hit;
  logic halt_q, irq_q;
  logic tick, en_eff, load_ok;
  logic [CNT_W-1:0]   cnt;
  logic [NUM_OUT-1:0] raw;
  hb_ctrl_t           ctrl;

  hbp_sync #(.STAGES(SYNC_STAGES)) u_sync_in (
    .clk(clk), .rst(rst), .d(sync_n), .q(sync_q)
  );

  hbp_sync #(.STAGES(SYNC_STAGES)) u_trip_in (
    .clk(clk), .rst(rst), .d(trip_n), .q(trip_q)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_prev <= 1'b1;
    else     sync_prev <= sync_q;
  end

  assign sync_fall  = sync_prev && !sync_q;
  assign sync_clear = cfg_sync_en && sync_fall;
  assign trip_hit   = cfg_trip_en && !trip_q;

  always_ff @(posedge clk) begin
    if (rst)             halt_q <= 1'b0;
    else if (trip_hit)   halt_q <= 1'b1;
    else if (!cfg_enable) halt_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)           irq_q <= 1'b0;
    else if (trip_hit) irq_q <= 1'b1;
    else if (irq_clr)  irq_q <= 1'b0;
  end

  assign en_eff  = cfg_enable && !halt_q;
  assign load_ok = !cfg_hbridge || cfg_reload;

  hbp_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .code(cfg_prescale), .clear(sync_clear), .tick(tick)
  );

  hbp_timebase #(.CNT_W(CNT_W), .NCH(NUM_OUT)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .clear(sync_clear), .load_ok(load_ok),
    .period(period), .cmp_flat(cmp_values), .cnt(cnt), .raw(raw)
  );

  assign ctrl = '{hbridge: cfg_hbridge, dir: cfg_dir, hs_off: cfg_hs_off, inv_all: cfg_inv_all};

  hbp_outstage u_out (
    .clk(clk), .rst(rst), .raw(raw), .en(en_eff), .ctrl(ctrl),
    .inv_odd(cfg_inv_odd), .pwm_q(pwm_out)
  );

  assign trip_irq = irq_q;
  assign tripped  = halt_q;
endmodule

// File: rtl/hbridge_pwm_chk.sv
module hbridge_pwm_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_enable,
  input logic             cfg_hbridge,
  input logic             cfg_dir,
  input logic             cfg_hs_off,
  input logic             cfg_inv_all,
  input logic [2:0]       cfg_inv_odd,
  input logic             cfg_sync_en,
  input logic             irq_clr,
  input logic [5:0]       pwm_out,
  input logic             trip_irq,
  input logic             tripped,
  input logic             sync_fall,
  input logic [CNT_W-1:0] cnt
);
  logic active, plain;
  assign active = cfg_enable && !tripped;
  assign plain  = !cfg_inv_all && (cfg_inv_odd == 3'b000);

  // R6: interrupt is sticky until cleared
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    trip_irq && !irq_clr |=> trip_irq);

  // R6: a trip raises the interrupt in the same cycle
  a_r6_irq_on_trip: assert property (@(posedge clk) disable iff (rst)
    $rose(tripped) |-> trip_irq);

  // R7: disabled outputs are low when nothing inverts them
  a_r7_disabled_low: assert property (@(posedge clk) disable iff (rst)
    !active && !cfg_hbridge && cfg_inv_odd == 3'b000 |=> pwm_out == 6'b000000);

  // R8: high-side-off pattern
  a_r8_hs_off: assert property (@(posedge clk) disable iff (rst)
    cfg_hbridge && cfg_hs_off && active && plain |=> pwm_out[3:0] == 4'b0101);

  // R9: direction 1 silences outputs 2/3
  a_r9_dir_fwd: assert property (@(posedge clk) disable iff (rst)
    cfg_hbridge && !cfg_hs_off && cfg_dir && active && plain |=> pwm_out[3:2] == 2'b00);

  // R9: direction 0 silences outputs 0/1
  a_r9_dir_rev: assert property (@(posedge clk) disable iff (rst)
    cfg_hbridge && !cfg_hs_off && !cfg_dir && active && plain |=> pwm_out[1:0] == 2'b00);

  // R5: detected sync edge clears the counter
  a_r5_sync_clear: assert property (@(posedge clk) disable iff (rst)
    cfg_sync_en && sync_fall |=> cnt == '0);
endmodule

bind hbridge_pwm hbridge_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_hbridge(cfg_hbridge),
  .cfg_dir(cfg_dir), .cfg_hs_off(cfg_hs_off), .cfg_inv_all(cfg_inv_all),
  .cfg_inv_odd(cfg_inv_odd), .cfg_sync_en(cfg_sync_en), .irq_clr(irq_clr),
  .pwm_out(pwm_out), .trip_irq(trip_irq), .tripped(tripped),
  .sync_fall(sync_fall), .cnt(cnt)
);

// File: tb/hbridge_pwm_test.sv
module hbridge_pwm_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 0, cfg_hbridge = 0, cfg_dir = 0, cfg_hs_off = 0;
  logic        cfg_reload = 0, cfg_inv_all = 0, cfg_sync_en = 0, cfg_trip_en = 0;
  logic [2:0]  cfg_inv_odd = 0, cfg_prescale = 0;
  logic [7:0]  period = 0;
  logic [47:0] cmp_values = 0;
  logic        sync_n = 1, trip_n = 1, irq_clr = 0;
  logic [5:0]  pwm_out;
  logic        trip_irq, tripped;

  int    n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  logic  cmp_on = 1'b0;
  logic  done = 1'b0;

  always #10 clk = ~clk;

  hbridge_pwm uut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_hbridge(cfg_hbridge),
    .cfg_dir(cfg_dir), .cfg_hs_off(cfg_hs_off), .cfg_reload(cfg_reload),
    .cfg_inv_all(cfg_inv_all), .cfg_inv_odd(cfg_inv_odd), .cfg_sync_en(cfg_sync_en),
    .cfg_trip_en(cfg_trip_en), .cfg_prescale(cfg_prescale), .period(period),
    .cmp_values(cmp_values), .sync_n(sync_n), .trip_n(trip_n), .irq_clr(irq_clr),
    .pwm_out(pwm_out), .trip_irq(trip_irq), .tripped(tripped)
  );

  // expected output shape, written from the requirements
  function automatic logic [5:0] exp_shape(input logic [7:0] c, input logic [47:0] sh,
                                           input logic en);
    logic [5:0] o;
    for (int i = 0; i < 6; i++) o[i] = en && (c < sh[i*8 +: 8]);       // R3, R7
    if (cfg_hbridge && en) begin
      if (cfg_hs_off) o[3:0] = 4'b0101;                                   // R8
      else if (cfg_dir) o[3:2] = 2'b00;                                   // R9
      else o[1:0] = 2'b00;
    end
    o = o ^ {cfg_inv_odd[2], 1'b0, cfg_inv_odd[1], 1'b0, cfg_inv_odd[0], 1'b0}; // R10
    if (cfg_hbridge && cfg_inv_all) o = ~o;                               // R10, R11
    return o;
  endfunction

  // cycle model
  logic m_t1, m_t2, m_s1, m_s2, m_s3, m_halt, m_irq;
  int   m_pre;
  logic [7:0]  m_cnt;
  logic [47:0] m_sh;
  logic [5:0]  m_out;

  always @(posedge clk) begin
    logic hit, clr, tick;
    if (rst) begin
      m_t1 <= 1; m_t2 <= 1; m_s1 <= 1; m_s2 <= 1; m_s3 <= 1;
      m_halt <= 0; m_irq <= 0; m_pre <= 0; m_cnt <= 0; m_sh <= 0; m_out <= 0;
    end else begin
      m_t1 <= trip_n; m_t2 <= m_t1;
      m_s1 <= sync_n; m_s2 <= m_s1; m_s3 <= m_s2;
      hit  = cfg_trip_en && !m_t2;
      clr  = cfg_sync_en && m_s3 && !m_s2;
      tick = (m_pre >= (2 << cfg_prescale) - 1);
      if (hit) m_halt <= 1; else if (!cfg_enable) m_halt <= 0;
      if (hit) m_irq <= 1; else if (irq_clr) m_irq <= 0;
      if (clr || tick) m_pre <= 0; else m_pre <= m_pre + 1;
      if (clr) m_cnt <= 0;
      else if (tick) m_cnt <= (m_cnt >= period) ? 8'd0 : m_cnt + 8'd1;
      if (!clr && tick && m_cnt == 0 && period != 0 && (!cfg_hbridge || cfg_reload))
        m_sh <= cmp_values;
      m_out <= exp_shape(m_cnt, m_sh, cfg_enable && !m_halt);
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison (R12 latency included)
  always @(negedge clk) begin
    if (!rst && cmp_on && !done)
      check({cur_req, " R12"}, {24'd0, pwm_out, trip_irq, tripped}, {24'd0, m_out, m_irq, m_halt});
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int high;
    void'($urandom(32'h5EED_0042));
    cyc(3);
    check("R1 reset outputs", {26'd0, pwm_out}, 32'd0);
    check("R1 reset irq", {31'd0, trip_irq}, 32'd0);
    check("R1 reset tripped", {31'd0, tripped}, 32'd0);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R2: divider ends, both windows give 512 high cycles out of 2048
    cur_req = "R2";
    cfg_enable = 1; period = 8'd3; cmp_values = 48'h01;
    cfg_prescale = 3'd0;
    cyc(64);
    high = 0;
    for (int i = 0; i < 2048; i++) begin @(negedge clk); high += pwm_out[0]; end
    check("R2 code0 high time", high, 512);
    cfg_prescale = 3'd7;
    cyc(1100);
    high = 0;
    for (int i = 0; i < 2048; i++) begin @(negedge clk); high += pwm_out[0]; end
    check("R2 code7 high time", high, 512);

    // R4: H-bridge compare hold without reload, then reload
    cur_req = "R4";
    cfg_prescale = 3'd0; period = 8'd9; cfg_hbridge = 1; cfg_dir = 1;
    cmp_values = {8'd2, 8'd4, 8'd6, 8'd8, 8'd3, 8'd5};
    cyc(60);
    cfg_reload = 1; cyc(60);
    cfg_reload = 0; cmp_values = {8'd9, 8'd1, 8'd2, 8'd3, 8'd4, 8'd7}; cyc(60);

    // R11: standard mode ignores the H-bridge controls
    cur_req = "R11";
    cfg_hbridge = 0; cfg_hs_off = 1; cfg_inv_all = 1; cfg_dir = 0; cyc(60);
    cfg_hs_off = 0; cfg_inv_all = 0; cfg_dir = 1; cyc(60);

    // R5: sync ignored, then acting
    cur_req = "R5";
    cfg_prescale = 3'd2; period = 8'd40;
    for (int k = 0; k < 4; k++) begin sync_n = 0; cyc(7); sync_n = 1; cyc(23); end
    cfg_sync_en = 1;
    for (int k = 0; k < 4; k++) begin sync_n = 0; cyc(7); sync_n = 1; cyc(23); end
    cfg_sync_en = 0;

    // R6: trip, release, re-enable, clear
    cur_req = "R6";
    cfg_trip_en = 1; trip_n = 0; cyc(1); trip_n = 1; cyc(5);
    check("R6 tripped set", {31'd0, tripped}, 32'd1);
    check("R6 irq set", {31'd0, trip_irq}, 32'd1);
    check("R7 outputs low while tripped", {26'd0, pwm_out}, 32'd0);
    cyc(20);
    check("R6 tripped held", {31'd0, tripped}, 32'd1);
    cfg_enable = 0; cyc(1); cfg_enable = 1; cyc(2);
    check("R6 tripped cleared by enable", {31'd0, tripped}, 32'd0);
    check("R6 irq still set", {31'd0, trip_irq}, 32'd1);
    irq_clr = 1; cyc(1); irq_clr = 0; cyc(1);
    check("R6 irq cleared", {31'd0, trip_irq}, 32'd0);

    // R8/R9/R10 directed in H-bridge mode
    cur_req = "R8";
    cfg_hbridge = 1; cfg_hs_off = 1; cfg_prescale = 0; period = 8'd7; cyc(40);
    cfg_inv_all = 1; cyc(40);
    cur_req = "R9";
    cfg_hs_off = 0; cfg_inv_all = 0; cfg_dir = 0; cyc(40);
    cfg_dir = 1; cyc(40);
    cur_req = "R10";
    cfg_inv_odd = 3'b101; cyc(40);
    cfg_inv_all = 1; cyc(40);
    cur_req = "R7";
    cfg_enable = 0; cyc(30);

    // random segments
    for (int s = 0; s < 80; s++) begin
      cur_req = "R3/R4/R5/R6/R7/R8/R9/R10/R11";
      cfg_enable   = ($urandom % 5) != 0;
      cfg_hbridge  = $urandom % 2;
      cfg_dir      = $urandom % 2;
      cfg_hs_off   = ($urandom % 4) == 0;
      cfg_reload   = $urandom % 2;
      cfg_inv_all  = $urandom % 2;
      cfg_inv_odd  = 3'($urandom);
      cfg_sync_en  = $urandom % 2;
      cfg_trip_en  = ($urandom % 3) == 0;
      cfg_prescale = 3'($urandom % 4);
      period       = 8'($urandom % 24);
      for (int ch = 0; ch < 6; ch++) cmp_values[ch*8 +: 8] = 8'($urandom % 28);
      for (int c = 0; c < 250; c++) begin
        @(negedge clk);
        if ($urandom % 40 == 0) sync_n = ~sync_n;
        trip_n  = ($urandom % 150) != 0;
        irq_clr = ($urandom % 60) == 0;
      end
      trip_n = 1; irq_clr = 0;
    end

    cyc(2);
    finish_run();
  end
endmodule